// File: doc/BRIEF.md
# JTAG TAP State Navigator

This block keeps a copy of the state of a target's JTAG test access port controller. It builds that copy from the TMS bits it drives itself. When a requested state is latched, it issues TMS values one TCK at a time, each chosen by a fixed per-state rule. Each value moves the port one step closer to the requested state. Every clock cycle with `step_o` high is one TCK, and `tms_o` is the level to present during that TCK. The tracked state moves on the same clock edge.

The data-register and instruction-register arms are mirror images. They share seven inner sub-states: select, capture, shift, exit-one, pause, exit-two and update. A target outside the current arm is reached by leaving through that arm's update state. A hard-reset request runs a fixed pattern of TMS-high clocks followed by one TMS-low clock. This parks the port in Run-Test/Idle whatever its starting state. Moving TDI and TDO data is left to the surrounding logic.

Top module: `tap_walker`

## Requirements
- R1: States use a 4-bit code. Bit 3 selects the instruction arm and bits 2:0 give the sub-state: 0 = outside any arm, 1 select, 2 capture, 3 shift, 4 exit-one, 5 pause, 6 exit-two, 7 update. Test-Logic-Reset is 4'h0 and Run-Test/Idle is 4'h8. After reset the state is 4'h0, the target is 4'h0, `arrived_o` is 1 and `step_o` is 0.
- R2: A step with TMS 0 moves the tracked state as follows: reset to idle; select to capture; capture or shift to shift; exit-one or pause to pause; exit-two to shift; update to idle.
- R3: A step with TMS 1 moves the tracked state as follows: reset stays in reset; idle goes to data select; data select goes to instruction select; instruction select goes to reset; capture or shift goes to exit-one; exit-one or exit-two goes to update; pause goes to exit-two; update goes to data select.
- R4: The step rule outside the scan arms is: from reset drive 0; from idle drive 1. From a select state, drive 0 only when the target lies inside that same arm.
- R5: From an update state, drive 1 when the target lies in either arm, and 0 otherwise.
- R6: Inside an arm, the goal is the target's sub-state when the target is in the same arm, and update otherwise. TMS is 0 in three cases: capture with goal shift; exit-one with goal pause or exit-two; exit-two with goal shift, exit-one or pause. TMS is 1 in every other case.
- R7: While the tracked state equals the latched target and no hard reset runs, `step_o` is 0, `arrived_o` is 1 in that same cycle, and the state holds.
- R8: A `go_i` pulse latches `target_i`, and stepping starts in the next cycle. For example, from idle a shift-data target (4'h3) is reached in 3 steps.
- R9: A `hard_reset_i` pulse starts a sequence in the next cycle: `HRST_HIGH` steps with TMS 1, then one step with TMS 0. The block then ends in idle (4'h8) with that as its target. `go_i` and `hard_reset_i` are ignored while the sequence runs.
- R10: Five TMS-high steps bring the tracked state to reset from any state, including shift-instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one TCK per stepping cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| target_i | input | 4 | Requested state code |
| go_i | input | 1 | Latch `target_i` as the new target |
| hard_reset_i | input | 1 | Start the fixed reset pattern |
| tms_o | output | 1 | TMS level for the current step |
| step_o | output | 1 | A TCK is issued this cycle |
| state_o | output | 4 | Tracked port state |
| arrived_o | output | 1 | Tracked state equals target |

## Verification
The bench uses the default `HRST_HIGH` of 5. At that value the hard-reset pattern both reaches Test-Logic-Reset and, with its final low step, exits to idle. This makes the five-high-step guarantee of R10 observable from the deepest state, shift-instruction. Random targets among all sixteen codes, drawn mid-walk as well as at rest, exercise every greedy rule: cross-arm walks through update, pause loops and walks that pass through reset. Directed walks cover the step count from idle and go pulses raised during a hard reset.

// File: rtl/tap_nav_pkg.sv
package tap_nav_pkg;
  localparam int unsigned ST_W = 4;
  localparam logic [2:0] SUB_NONE = 3'd0;
  localparam logic [2:0] SUB_SEL  = 3'd1;
  localparam logic [2:0] SUB_CAP  = 3'd2;
  localparam logic [2:0] SUB_SHF  = 3'd3;
  localparam logic [2:0] SUB_EX1  = 3'd4;
  localparam logic [2:0] SUB_PAU  = 3'd5;
  localparam logic [2:0] SUB_EX2  = 3'd6;
  localparam logic [2:0] SUB_UPD  = 3'd7;
  localparam logic [ST_W-1:0] ST_TLR  = 4'h0;
  localparam logic [ST_W-1:0] ST_RTI  = 4'h8;
  localparam logic [ST_W-1:0] ST_DSEL = 4'h1;
  localparam logic [ST_W-1:0] ST_ISEL = 4'h9;
endpackage

// File: rtl/tap_nav_next.sv
module tap_nav_next
  import tap_nav_pkg::*;
(
  input  logic [ST_W-1:0] cur_i,
  input  logic            tms_i,
  output logic [ST_W-1:0] nxt_o
);
  logic       arm;
  logic [2:0] sub;

  always_comb begin
    arm   = cur_i[3];
    sub   = cur_i[2:0];
    nxt_o = cur_i;
    case (sub)
      SUB_NONE: begin
        if (!arm) nxt_o = tms_i ? ST_TLR : ST_RTI;
        else      nxt_o = tms_i ? ST_DSEL : ST_RTI;
      end
      SUB_SEL: begin
        if (tms_i) nxt_o = arm ? ST_TLR : ST_ISEL;
        else       nxt_o = {arm, SUB_CAP};
      end
      SUB_CAP, SUB_SHF: nxt_o = {arm, (tms_i ? SUB_EX1 : SUB_SHF)};
      SUB_EX1:          nxt_o = {arm, (tms_i ? SUB_UPD : SUB_PAU)};
      SUB_PAU:          nxt_o = {arm, (tms_i ? SUB_EX2 : SUB_PAU)};
      SUB_EX2:          nxt_o = {arm, (tms_i ? SUB_UPD : SUB_SHF)};
      default:          nxt_o = tms_i ? ST_DSEL : ST_RTI;
    endcase
  end
endmodule

// File: rtl/tap_nav_rule.sv
module tap_nav_rule
  import tap_nav_pkg::*;
(
  input  logic [ST_W-1:0] cur_i,
  input  logic [ST_W-1:0] tgt_i,
  output logic            tms_o
);
  logic       tgt_in_arm;
  logic       same_arm;
  logic [2:0] goal;

  always_comb begin
    tgt_in_arm = (tgt_i[2:0] != SUB_NONE);
    same_arm   = tgt_in_arm && (tgt_i[3] == cur_i[3]);
    goal       = same_arm ? tgt_i[2:0] : SUB_UPD;
    tms_o      = 1'b1;
    case (cur_i[2:0])
      SUB_NONE: tms_o = cur_i[3];
      SUB_SEL:  tms_o = !same_arm;
      SUB_UPD:  tms_o = tgt_in_arm;
      SUB_CAP:  tms_o = (goal != SUB_SHF);
      SUB_EX1:  tms_o = !((goal == SUB_PAU) || (goal == SUB_EX2));
      SUB_EX2:  tms_o = !((goal == SUB_SHF) || (goal == SUB_EX1) || (goal == SUB_PAU));
      default:  tms_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/tap_walker.sv
module tap_walker
  import tap_nav_pkg::*;
#(
  parameter int unsigned HRST_HIGH = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] target_i,
  input  logic       go_i,
  input  logic       hard_reset_i,
  output logic       tms_o,
  output logic       step_o,
  output logic [3:0] state_o,
  output logic       arrived_o
);
  localparam int unsigned CW = $clog2(HRST_HIGH + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(HRST_HIGH);

  logic [1:0]      rsync_q;
  logic            srst_n;
  logic [ST_W-1:0] cur_q, cur_d, tgt_q, tgt_d, nxt;
  logic            hr_q, hr_d, rule_tms;
  logic [CW-1:0]   cnt_q, cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  tap_nav_rule u_rule (.cur_i(cur_q), .tgt_i(tgt_q), .tms_o(rule_tms));
  tap_nav_next u_next (.cur_i(cur_q), .tms_i(tms_o), .nxt_o(nxt));

  always_comb begin
    step_o    = hr_q || (cur_q != tgt_q);
    tms_o     = hr_q ? (cnt_q != CNT_LAST) : rule_tms;
    arrived_o = !hr_q && (cur_q == tgt_q);
    cur_d     = step_o ? nxt : cur_q;
    tgt_d     = tgt_q;
    hr_d      = hr_q;
    cnt_d     = cnt_q;
    if (hr_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) begin
        hr_d  = 1'b0;
        cnt_d = '0;
        tgt_d = ST_RTI;
      end
    end else if (hard_reset_i) begin
      hr_d  = 1'b1;
      cnt_d = '0;
    end else if (go_i) begin
      tgt_d = target_i;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cur_q <= ST_TLR;
      tgt_q <= ST_TLR;
      hr_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (step_o) cur_q <= cur_d;
      tgt_q <= tgt_d;
      hr_q  <= hr_d;
      cnt_q <= cnt_d;
    end
  end

  assign state_o = cur_q;
endmodule

// File: rtl/tap_walker_chk.sv
module tap_walker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tms_o,
  input logic       step_o,
  input logic [3:0] state_o,
  input logic       arrived_o
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !step_o |=> $stable(state_o));
  assert_arrive_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arrived_o |-> !step_o);
  assert_reset_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && !tms_o && state_o == 4'h0) |=> (state_o == 4'h8));
  assert_isel_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && tms_o && state_o == 4'h9) |=> (state_o == 4'h0));
  assert_update_loop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && tms_o && state_o[2:0] == 3'd7) |=> (state_o == 4'h1));
  assert_idle_leave_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && state_o == 4'h8) |-> tms_o);
endmodule

bind tap_walker tap_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tms_o(tms_o), .step_o(step_o),
  .state_o(state_o), .arrived_o(arrived_o));

// File: tb/sim_tap_walker.sv
`timescale 1ns/1ps
module sim_tap_walker;
  logic clk = 1'b0, rst_n = 1'b0, go_i = 1'b0, hard_reset_i = 1'b0;
  logic [3:0] target_i = 4'h0;
  logic tms_o, step_o, arrived_o;
  logic [3:0] state_o;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [3:0] m_cur, m_tgt;
  logic m_hr;
  int m_cnt;
  logic last_tms;

  always #4 clk = ~clk;

  tap_walker #(.HRST_HIGH(5)) u0 (.clk(clk), .rst_n(rst_n), .target_i(target_i),
    .go_i(go_i), .hard_reset_i(hard_reset_i), .tms_o(tms_o), .step_o(step_o),
    .state_o(state_o), .arrived_o(arrived_o));

  function automatic logic [3:0] f_next(logic [3:0] s, logic t);
    logic [2:0] u = s[2:0];
    if (u == 0) return (s[3] ? (t ? 4'h1 : 4'h8) : (t ? 4'h0 : 4'h8));
    if (u == 1) return t ? (s[3] ? 4'h0 : 4'h9) : {s[3], 3'd2};
    if (u == 2 || u == 3) return {s[3], t ? 3'd4 : 3'd3};
    if (u == 4) return {s[3], t ? 3'd7 : 3'd5};
    if (u == 5) return {s[3], t ? 3'd6 : 3'd5};
    if (u == 6) return {s[3], t ? 3'd7 : 3'd3};
    return t ? 4'h1 : 4'h8;
  endfunction

  function automatic logic f_rule(logic [3:0] s, logic [3:0] g);
    logic inarm = (g[2:0] != 0);
    logic same = inarm && (g[3] == s[3]);
    logic [2:0] goal = same ? g[2:0] : 3'd7;
    case (s[2:0])
      3'd0: return s[3];
      3'd1: return !same;
      3'd7: return inarm;
      3'd2: return goal != 3'd3;
      3'd4: return !(goal == 3'd5 || goal == 3'd6);
      3'd6: return !(goal == 3'd3 || goal == 3'd4 || goal == 3'd5);
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    logic es = m_hr || (m_cur != m_tgt);
    logic et = m_hr ? (m_cnt != 5) : f_rule(m_cur, m_tgt);
    string ttag;
    chk(m_hr ? "R9 state" : (last_tms ? "R3 state" : "R2 state"), state_o, m_cur);
    chk("R7 step", step_o, es);
    chk("R7 arrived", arrived_o, !m_hr && m_cur == m_tgt);
    if (es) begin
      if (m_hr) ttag = "R9 tms";
      else if (m_cur[2:0] == 0 || m_cur[2:0] == 1) ttag = "R4 tms";
      else if (m_cur[2:0] == 7) ttag = "R5 tms";
      else ttag = "R6 tms";
      chk(ttag, tms_o, et);
    end
  endtask

  task automatic tick(input logic g, input logic [3:0] t, input logic h);
    logic es, et;
    check_outputs();
    go_i = g; target_i = t; hard_reset_i = h;
    es = m_hr || (m_cur != m_tgt);
    et = m_hr ? (m_cnt != 5) : f_rule(m_cur, m_tgt);
    if (es) begin m_cur = f_next(m_cur, et); last_tms = et; end
    if (m_hr) begin
      if (m_cnt == 5) begin m_hr = 0; m_cnt = 0; m_tgt = 4'h8; end
      else m_cnt++;
    end else if (h) begin m_hr = 1; m_cnt = 0; end
    else if (g) m_tgt = t;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd7));
    m_cur = 4'h0; m_tgt = 4'h0; m_hr = 0; m_cnt = 0; last_tms = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 state", state_o, 4'h0);
    chk("R1 arrived", arrived_o, 1);
    chk("R1 step", step_o, 0);
    // R8: reach idle, then shift-data in 3 steps
    tick(1, 4'h8, 0);
    while (!arrived_o) tick(0, 4'h0, 0);
    tick(1, 4'h3, 0);
    chk("R8 first step", step_o, 1);
    n = 0;
    while (!arrived_o && n < 20) begin n++; tick(0, 4'h0, 0); end
    chk("R8 step count", n, 3);
    chk("R8 final", state_o, 4'h3);
    // R10 / R9: hard reset from shift-instruction
    tick(1, 4'hB, 0);
    while (!arrived_o) tick(0, 4'h0, 0);
    chk("R10 start", state_o, 4'hB);
    tick(0, 4'h0, 1);
    for (int i = 0; i < 5; i++) tick((i == 2), 4'h5, (i == 3));
    chk("R10 reset reached", state_o, 4'h0);
    tick(1, 4'h3, 1);
    chk("R9 idle", state_o, 4'h8);
    chk("R9 arrived", arrived_o, 1);
    tick(0, 4'h0, 0);
    chk("R9 go ignored", state_o, 4'h8);
    // random walk
    for (int c = 0; c < 6000; c++) begin
      int r = $urandom_range(0, 99);
      logic [3:0] t = 4'($urandom_range(0, 15));
      if (r < 2) tick(0, t, 1);
      else if (r < (arrived_o ? 40 : 8)) tick(1, t, 0);
      else tick(0, t, 0);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule